// File: doc/BRIEF.md
# Quasi-Resonant Flyback Gate Timer

This block decides when the primary switch of a quasi-resonant flyback converter is on and when it is off. The analog front end reduces everything to digital flags: the switch current has crossed its limit, the on-time demand from the control loop has been met, the resonant drain voltage has reached a valley, and the sampled winding plateau is above the output over-voltage level. A quantised feedback code arrives alongside them. All timing is counted in clock cycles. The parameter defaults assume an 8 ns clock.

Each switching period has an on phase and an off phase. The on phase ends on the demand flag, on a current-limit flag that arrives after a short blanking window, or at a hard maximum. The off phase imposes a minimum off time. That time shrinks linearly as the feedback code rises between a light-load code and a heavier-load code, and it is clamped outside that span. After the minimum off time, the first valley starts a short turn-on delay. If no valley arrives within a fixed timeout, the switch turns on anyway. When the feedback code drops below the light-load code, a hysteretic standby mode replaces valley switching with a long fixed start timer.

While the switch is off and past the blanking window, the block watches the plateau over-voltage flag. A long enough unbroken run of high samples raises a latch request that holds the switch off until reset. A soft-start level climbs one step per fixed interval after reset, and the current-limit path uses it as a peak-current ceiling.

Top module: `qrf_gate_timer`

## Requirements
- R1: When the on-demand flag is sampled high in the k-th on cycle (counting from 0), the gate stays high for exactly k+1 cycles.
- R2: With no terminating flag, the gate stays high for exactly TON_MAX_CYC cycles, and never for longer.
- R3: The current-limit flag has no effect during on cycles 0 to LEB_CYC-1. Sampled high in on cycle k with k at least LEB_CYC, it ends the on phase after k+1 cycles.
- R4: The minimum off time is TMIN_SHORT when the feedback code is at or above FB_GON, and TMIN_LONG at or below FB_GOFF. Between those codes it is TMIN_SHORT + floor((FB_GON-code)*(TMIN_LONG-TMIN_SHORT)/(FB_GON-FB_GOFF)).
- R5: The valley flag counts only when sampled in off cycle c with c at or above both the minimum off time and BLANK_CYC. The gate is then low for c+1+VDLY_CYC cycles. A valley sampled earlier than that has no effect.
- R6: If no valley counts, the gate is low for exactly the minimum off time plus TMO_CYC cycles, and then turns on.
- R7: A code below FB_GOFF enters standby, and only a code at or above FB_GOFF+FB_HYS leaves it. In standby, valleys have no effect and every off phase lasts exactly START_CYC cycles.
- R8: The plateau flag is sampled only in off cycles at or after BLANK_CYC. A low sample clears the run count. After OVP_DEB_CYC consecutive high samples, the latch request rises one cycle later and stays high until reset. From the next cycle on, the gate stays low.
- R9: The soft-start level equals floor(N/SS_STEP_CYC) after N clock edges out of reset, and saturates at all ones.
- R10: During reset the gate, the latch request and the soft-start level are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fb_code_i | input | FB_W | Quantised feedback code |
| valley_i | input | 1 | Valley detected on the resonant ring |
| ocp_i | input | 1 | Switch current above limit |
| ton_done_i | input | 1 | On-time demand reached |
| plateau_ovp_i | input | 1 | Winding plateau above output OVP level |
| gate_o | output | 1 | Switch gate command |
| ovp_latch_o | output | 1 | Latched over-voltage shutdown request |
| ss_limit_o | output | SS_W | Soft-start peak-current ceiling level |

## Verification
The gate is a registered output. A flag that the bench drives on a falling edge is sampled at the next rising edge and changes the gate right at that edge. The bench therefore measures each on and off phase as the number of falling edges at which the gate holds that level, and compares that count with widths derived from R1 to R7. The latch request lags the deciding plateau sample by one cycle, so the bench expects it at the falling edge one off-cycle after the final required sample. The bench compares the soft-start level against its own count of rising edges since reset release. Feedback changes are applied at the start of an on phase, which gives the one-cycle registered minimum-off-time and standby state time to settle before they are used.

// File: rtl/qrf_pkg.sv
package qrf_pkg;

    typedef enum logic [1:0] {
        PH_OFF   = 2'd0,
        PH_VWAIT = 2'd1,
        PH_ON    = 2'd2,
        PH_LATCH = 2'd3
    } qrf_phase_e;

endpackage

// File: rtl/qrf_toff_sched.sv
module qrf_toff_sched #(
    parameter int FB_W       = 8,
    parameter int FB_GON     = 168,
    parameter int FB_GOFF    = 96,
    parameter int FB_HYS     = 8,
    parameter int TMIN_SHORT = 1063,
    parameter int TMIN_LONG  = 4500,
    parameter int T_W        = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FB_W-1:0] fb_code_i,
    output logic [T_W-1:0]  tmin_o,
    output logic            standby_o
);
    localparam int SPAN_T = TMIN_LONG - TMIN_SHORT;
    localparam int SPAN_F = FB_GON - FB_GOFF;
    localparam logic [FB_W-1:0] GON_C  = FB_W'(FB_GON);
    localparam logic [FB_W-1:0] GOFF_C = FB_W'(FB_GOFF);
    localparam logic [FB_W-1:0] EXIT_C = FB_W'(FB_GOFF + FB_HYS);

    typedef struct packed {
        logic [T_W-1:0] tmin;
        logic           standby;
    } sched_t;

    sched_t sch_d, sch_q;
    logic [31:0] delta_fb;
    logic [31:0] prod;
    logic [31:0] quo;

    always_comb begin
        sch_d    = sch_q;
        delta_fb = 32'(GON_C) - 32'(fb_code_i);
        prod     = delta_fb * 32'(SPAN_T);
        quo      = prod / 32'(SPAN_F);
        // linear schedule between the two end points, clamped outside
        if (fb_code_i >= GON_C) begin
            sch_d.tmin = T_W'(TMIN_SHORT);
        end else if (fb_code_i <= GOFF_C) begin
            sch_d.tmin = T_W'(TMIN_LONG);
        end else begin
            sch_d.tmin = T_W'(32'(TMIN_SHORT) + quo);
        end
        // standby with hysteresis on the exit threshold
        if (fb_code_i < GOFF_C) begin
            sch_d.standby = 1'b1;
        end else if (fb_code_i >= EXIT_C) begin
            sch_d.standby = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sch_q.tmin    <= T_W'(TMIN_LONG);
            sch_q.standby <= 1'b0;
        end else begin
            sch_q <= sch_d;
        end
    end

    assign tmin_o    = sch_q.tmin;
    assign standby_o = sch_q.standby;

endmodule

// File: rtl/qrf_ovp_debounce.sv
module qrf_ovp_debounce #(
    parameter int DEB_CYC = 18750,
    parameter int D_W     = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    input  logic ovp_i,
    output logic latch_o
);
    localparam logic [D_W-1:0] LAST_C = D_W'(DEB_CYC - 1);
    localparam logic [D_W-1:0] ONE_C  = D_W'(1);

    typedef struct packed {
        logic [D_W-1:0] run;
        logic           latched;
    } deb_t;

    deb_t deb_d, deb_q;

    always_comb begin
        deb_d = deb_q;
        if (!deb_q.latched && sample_i) begin
            if (ovp_i) begin
                if (deb_q.run == LAST_C) begin
                    deb_d.latched = 1'b1;
                end else begin
                    deb_d.run = deb_q.run + ONE_C;
                end
            end else begin
                deb_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            deb_q <= '0;
        end else begin
            deb_q <= deb_d;
        end
    end

    assign latch_o = deb_q.latched;

endmodule

// File: rtl/qrf_softstart.sv
module qrf_softstart #(
    parameter int SS_W        = 6,
    parameter int SS_STEP_CYC = 19048,
    parameter int P_W         = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [SS_W-1:0] level_o
);
    localparam logic [P_W-1:0]  PRE_LAST = P_W'(SS_STEP_CYC - 1);
    localparam logic [P_W-1:0]  PRE_ONE  = P_W'(1);
    localparam logic [SS_W-1:0] LVL_ONE  = SS_W'(1);

    typedef struct packed {
        logic [P_W-1:0]  pre;
        logic [SS_W-1:0] lvl;
    } ss_t;

    ss_t ss_d, ss_q;

    always_comb begin
        ss_d = ss_q;
        if (ss_q.pre == PRE_LAST) begin
            ss_d.pre = '0;
            if (ss_q.lvl != {SS_W{1'b1}}) begin
                ss_d.lvl = ss_q.lvl + LVL_ONE;
            end
        end else begin
            ss_d.pre = ss_q.pre + PRE_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ss_q <= '0;
        end else begin
            ss_q <= ss_d;
        end
    end

    assign level_o = ss_q.lvl;

endmodule

// File: rtl/qrf_gate_timer.sv
module qrf_gate_timer
    import qrf_pkg::*;
#(
    parameter int FB_W        = 8,
    parameter int FB_GON      = 168,
    parameter int FB_GOFF     = 96,
    parameter int FB_HYS      = 8,
    parameter int TMIN_SHORT  = 1063,
    parameter int TMIN_LONG   = 4500,
    parameter int TMO_CYC     = 750,
    parameter int BLANK_CYC   = 500,
    parameter int VDLY_CYC    = 25,
    parameter int LEB_CYC     = 38,
    parameter int TON_MAX_CYC = 5625,
    parameter int START_CYC   = 312500,
    parameter int OVP_DEB_CYC = 18750,
    parameter int SS_W        = 6,
    parameter int SS_STEP_CYC = 19048
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FB_W-1:0] fb_code_i,
    input  logic            valley_i,
    input  logic            ocp_i,
    input  logic            ton_done_i,
    input  logic            plateau_ovp_i,
    output logic            gate_o,
    output logic            ovp_latch_o,
    output logic [SS_W-1:0] ss_limit_o
);
    localparam int OFF_MAX = TMIN_LONG + TMO_CYC;
    localparam int M1      = (START_CYC > OFF_MAX) ? START_CYC : OFF_MAX;
    localparam int M2      = (M1 > TON_MAX_CYC) ? M1 : TON_MAX_CYC;
    localparam int CNT_W   = $clog2(M2 + 1);
    localparam int T_W     = $clog2(TMIN_LONG + 1);
    localparam int D_W     = $clog2(OVP_DEB_CYC + 1);
    localparam int P_W     = $clog2(SS_STEP_CYC + 1);

    localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);
    localparam logic [CNT_W-1:0] LEB_C    = CNT_W'(LEB_CYC);
    localparam logic [CNT_W-1:0] BLANK_C  = CNT_W'(BLANK_CYC);
    localparam logic [CNT_W-1:0] TONL_C   = CNT_W'(TON_MAX_CYC - 1);
    localparam logic [CNT_W-1:0] VDLYL_C  = CNT_W'(VDLY_CYC - 1);
    localparam logic [CNT_W-1:0] STARTL_C = CNT_W'(START_CYC - 1);
    localparam logic [CNT_W-1:0] TMOL_C   = CNT_W'(TMO_CYC - 1);

    typedef struct packed {
        qrf_phase_e       phase;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic [T_W-1:0]   tmin;
    logic             standby;
    logic             latch_req;
    logic             ovp_sample;
    logic [CNT_W-1:0] tmin_ext;
    logic [CNT_W-1:0] timeout_at;
    logic             on_end;
    logic             valley_ok;

    qrf_toff_sched #(
        .FB_W      (FB_W),
        .FB_GON    (FB_GON),
        .FB_GOFF   (FB_GOFF),
        .FB_HYS    (FB_HYS),
        .TMIN_SHORT(TMIN_SHORT),
        .TMIN_LONG (TMIN_LONG),
        .T_W       (T_W)
    ) sched_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fb_code_i(fb_code_i),
        .tmin_o   (tmin),
        .standby_o(standby)
    );

    qrf_ovp_debounce #(
        .DEB_CYC(OVP_DEB_CYC),
        .D_W    (D_W)
    ) ovp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample_i(ovp_sample),
        .ovp_i   (plateau_ovp_i),
        .latch_o (latch_req)
    );

    qrf_softstart #(
        .SS_W       (SS_W),
        .SS_STEP_CYC(SS_STEP_CYC),
        .P_W        (P_W)
    ) ss_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .level_o(ss_limit_o)
    );

    // plateau is valid only once the turn-off ringing blank has passed
    assign ovp_sample = (fsm_q.phase == PH_OFF) && (fsm_q.cnt >= BLANK_C);

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.cnt  = fsm_q.cnt + ONE_C;
        tmin_ext   = CNT_W'(tmin);
        timeout_at = tmin_ext + TMOL_C;
        on_end     = ton_done_i
                   || (ocp_i && (fsm_q.cnt >= LEB_C))
                   || (fsm_q.cnt == TONL_C);
        valley_ok  = valley_i && (fsm_q.cnt >= tmin_ext) && (fsm_q.cnt >= BLANK_C);
        case (fsm_q.phase)
            PH_ON: begin
                if (latch_req) begin
                    fsm_d.phase = PH_LATCH;
                    fsm_d.cnt   = '0;
                end else if (on_end) begin
                    fsm_d.phase = PH_OFF;
                    fsm_d.cnt   = '0;
                end
            end
            PH_OFF: begin
                if (latch_req) begin
                    fsm_d.phase = PH_LATCH;
                    fsm_d.cnt   = '0;
                end else if (standby) begin
                    if (fsm_q.cnt >= STARTL_C) begin
                        fsm_d.phase = PH_ON;
                        fsm_d.cnt   = '0;
                    end
                end else if (fsm_q.cnt >= timeout_at) begin
                    fsm_d.phase = PH_ON;
                    fsm_d.cnt   = '0;
                end else if (valley_ok) begin
                    fsm_d.phase = PH_VWAIT;
                    fsm_d.cnt   = '0;
                end
            end
            PH_VWAIT: begin
                if (latch_req) begin
                    fsm_d.phase = PH_LATCH;
                    fsm_d.cnt   = '0;
                end else if (fsm_q.cnt >= VDLYL_C) begin
                    fsm_d.phase = PH_ON;
                    fsm_d.cnt   = '0;
                end
            end
            default: begin
                fsm_d.phase = PH_LATCH;
                fsm_d.cnt   = fsm_q.cnt;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.phase <= PH_OFF;
            fsm_q.cnt   <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign gate_o      = (fsm_q.phase == PH_ON);
    assign ovp_latch_o = latch_req;

endmodule

// File: rtl/qrf_gate_timer_chk.sv
module qrf_gate_timer_chk #(
    parameter int LEB_CYC     = 38,
    parameter int TON_MAX_CYC = 5625,
    parameter int SS_W        = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            gate_o,
    input logic            ocp_i,
    input logic            ton_done_i,
    input logic            ovp_latch_o,
    input logic [SS_W-1:0] ss_limit_o
);
    localparam int HW = $clog2(TON_MAX_CYC + 2);
    localparam logic [HW-1:0] LEB_H  = HW'(LEB_CYC);
    localparam logic [HW-1:0] TMAX_H = HW'(TON_MAX_CYC);

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (gate_o) begin
            hi_cnt <= hi_cnt + HW'(1);
        end else begin
            hi_cnt <= '0;
        end
    end

    // R1
    ton_done_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o && ton_done_i) |=> !gate_o);

    // R2
    on_time_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> (hi_cnt < TMAX_H));

    // R3
    ocp_after_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o && ocp_i && (hi_cnt >= LEB_H)) |=> !gate_o);

    // R8
    latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_latch_o |=> ovp_latch_o);

    // R8
    latch_gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_latch_o |=> !gate_o);

    // R9
    ss_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_limit_o != $past(ss_limit_o)) |-> (ss_limit_o == $past(ss_limit_o) + SS_W'(1)));

endmodule

bind qrf_gate_timer qrf_gate_timer_chk #(
    .LEB_CYC    (LEB_CYC),
    .TON_MAX_CYC(TON_MAX_CYC),
    .SS_W       (SS_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_o     (gate_o),
    .ocp_i      (ocp_i),
    .ton_done_i (ton_done_i),
    .ovp_latch_o(ovp_latch_o),
    .ss_limit_o (ss_limit_o)
);

// File: tb/qrf_gate_timer_tb_top.sv
module qrf_gate_timer_tb_top;
    localparam int FB_W   = 8;
    localparam int GON    = 168;
    localparam int GOFF   = 96;
    localparam int HYS    = 8;
    localparam int TS     = 20;
    localparam int TL     = 56;
    localparam int TMO    = 12;
    localparam int BLANK  = 8;
    localparam int VDLY   = 3;
    localparam int LEB    = 4;
    localparam int TONMAX = 60;
    localparam int START  = 300;
    localparam int OVPDEB = 50;
    localparam int SSW    = 4;
    localparam int SSSTEP = 40;

    // fb, on-demand cycle, current-limit cycle, valley cycle (-1 = none)
    localparam int NVEC = 13;
    localparam int VEC [NVEC][4] = '{
        '{200, 10, -1, -1},
        '{168, 15, -1, 25},
        '{132,  3,  2, -1},
        '{132, 20,  4, 40},
        '{ 96, -1, -1, 60},
        '{ 96,  8, -1, 30},
        '{200,  8, -1, 19},
        '{200,  8, -1, 20},
        '{200,  8, -1, 30},
        '{ 90,  6, -1, 100},
        '{100,  6, -1, -1},
        '{104,  6, -1, -1},
        '{150,  0, -1, -1}
    };

    logic            clk;
    logic            rst_n;
    logic [FB_W-1:0] fb_code;
    logic            valley;
    logic            ocp;
    logic            ton_done;
    logic            plateau;
    logic            gate;
    logic            latch;
    logic [SSW-1:0]  ss;

    int  n_chk  = 0;
    int  n_fail = 0;
    int  cyc    = 0;
    bit  done   = 0;
    bit  sb_m   = 0;

    qrf_gate_timer #(
        .FB_W(FB_W), .FB_GON(GON), .FB_GOFF(GOFF), .FB_HYS(HYS),
        .TMIN_SHORT(TS), .TMIN_LONG(TL), .TMO_CYC(TMO), .BLANK_CYC(BLANK),
        .VDLY_CYC(VDLY), .LEB_CYC(LEB), .TON_MAX_CYC(TONMAX), .START_CYC(START),
        .OVP_DEB_CYC(OVPDEB), .SS_W(SSW), .SS_STEP_CYC(SSSTEP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .fb_code_i(fb_code), .valley_i(valley),
        .ocp_i(ocp), .ton_done_i(ton_done), .plateau_ovp_i(plateau),
        .gate_o(gate), .ovp_latch_o(latch), .ss_limit_o(ss)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int tmin_calc(input int fb);
        if (fb >= GON) return TS;
        if (fb <= GOFF) return TL;
        return TS + ((GON - fb) * (TL - TS)) / (GON - GOFF);
    endfunction

    function automatic int ss_exp();
        int v = cyc / SSSTEP;
        return (v > 15) ? 15 : v;
    endfunction

    // at a falling edge that is the first high cycle; ends at the next one
    task automatic run_cycle(input int fb, input int ton_k, input int ocp_k,
                             input int val_k, input int mode,
                             output int hi, output int lo);
        int j = 0;
        hi = 0;
        lo = 0;
        fb_code = FB_W'(fb);
        while (gate === 1'b1 && hi < 5000) begin
            ton_done = (j == ton_k);
            ocp      = (j == ocp_k);
            plateau  = (mode != 0);
            hi++;
            j++;
            @(negedge clk);
        end
        ton_done = 1'b0;
        ocp      = 1'b0;
        j = 0;
        while (gate === 1'b0 && lo < 5000) begin
            valley  = (j == val_k);
            plateau = (mode == 1) || (mode == 2 && j != 31);
            lo++;
            j++;
            @(negedge clk);
        end
        valley = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int hi;
        int lo;
        int hexp;
        int lexp;
        int tm;
        int seen;
        int hi_seen;
        string htag;
        string ltag;
        rst_n    = 1'b0;
        fb_code  = 8'd200;
        valley   = 1'b0;
        ocp      = 1'b0;
        ton_done = 1'b0;
        plateau  = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10 gate in reset", int'(gate), 0);
        chk("R10 latch in reset", int'(latch), 0);
        chk("R10 soft-start in reset", int'(ss), 0);
        rst_n = 1'b1;
        begin
            int w = 0;
            while (gate !== 1'b1 && w < 1000) begin
                @(negedge clk);
                w++;
            end
        end
        chk("R9 soft-start level at first pulse", int'(ss), ss_exp());

        for (int v = 0; v < NVEC; v++) begin
            int fb = VEC[v][0];
            int tk = VEC[v][1];
            int ok = VEC[v][2];
            int vk = VEC[v][3];
            if (fb < GOFF) sb_m = 1'b1;
            else if (fb >= GOFF + HYS) sb_m = 1'b0;
            hexp = TONMAX;
            htag = "R2 max on width";
            if (tk >= 0 && tk + 1 < hexp) begin
                hexp = tk + 1;
                htag = "R1 on width";
            end
            if (ok >= LEB && ok + 1 < hexp) begin
                hexp = ok + 1;
                htag = "R3 on width";
            end
            tm = tmin_calc(fb);
            if (sb_m) begin
                lexp = START;
                ltag = "R7 standby off width";
            end else if (vk >= tm && vk >= BLANK && vk < tm + TMO - 1) begin
                lexp = vk + 1 + VDLY;
                ltag = "R5 valley off width";
            end else begin
                lexp = tm + TMO;
                ltag = "R4 R6 timeout off width";
            end
            run_cycle(fb, tk, ok, vk, 0, hi, lo);
            chk(htag, hi, hexp);
            chk(ltag, lo, lexp);
            chk("R9 soft-start level", int'(ss), ss_exp());
        end

        // plateau run broken by one low sample each period: no latch
        for (int p = 0; p < 4; p++) begin
            run_cycle(200, 5, -1, -1, 2, hi, lo);
        end
        chk("R8 broken runs give no latch", int'(latch), 0);
        // unbroken plateau: 24 samples per period after blanking
        for (int p = 0; p < 2; p++) begin
            run_cycle(200, 5, -1, -1, 1, hi, lo);
            chk("R8 off width before latch", lo, TS + TMO);
        end
        chk("R8 no latch after 48 samples", int'(latch), 0);
        begin
            int j = 0;
            while (gate === 1'b1 && j < 100) begin
                ton_done = (j == 5);
                plateau  = 1'b1;
                j++;
                @(negedge clk);
            end
            ton_done = 1'b0;
            seen = -1;
            for (int k = 0; k < 40; k++) begin
                if (latch === 1'b1 && seen < 0) seen = k;
                @(negedge clk);
            end
        end
        chk("R8 latch request timing", seen, BLANK + 2);
        hi_seen = 0;
        repeat (400) begin
            @(negedge clk);
            if (gate === 1'b1) hi_seen++;
        end
        chk("R8 gate held low after latch", hi_seen, 0);
        chk("R8 latch request held", int'(latch), 1);
        chk("R9 soft-start saturated", int'(ss), 15);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule